// File: doc/BRIEF.md
# PCM Voice Serial Port

This block is a full-duplex serial audio port. It joins the system-clock audio path to the PCM voice interface of a cellular modem. Each frame carries one 16-bit two's-complement sample in each direction. The block sends one word on a data-out line and takes one word in from a data-in line, both least-significant bit first. The first bit goes on the line in the bit period that follows a one-bit-period frame sync. Parallel samples go to and come from the rest of the system on single-cycle valid strobes.

The `slaveMode` input selects the timing source and may change at run time. With `slaveMode` low, the block makes the bit clock and the frame sync itself. It divides the system clock by an average of exactly 12.5, using a fixed high phase and a low phase that alternates between two lengths, and it drives both lines out. With `slaveMode` high, the block stops driving those lines. It takes the external clock and sync through a two-flop synchroniser and works its enables from the edges it detects.

Top module: `pcm_voice_port`

## Requirements
- R1: In master mode `pcmClkOut` stays high for 6 system cycles. Its low phase alternates between 6 and 7 cycles, so consecutive bit periods last 12 and 13 cycles.
- R2: In master mode a frame lasts 250 bit periods, so `pcmSyncOut` rises once every 3125 system cycles.
- R3: `pcmSyncOut` rises together with a rising edge of `pcmClkOut` and falls at the next one, so it is high for exactly one bit period (12 or 13 cycles).
- R4: The transmit word goes out on `pcmDout` with bit 0 in the first bit period after the sync, then bits 1 to 15 in the following periods. The line changes just after a bit-clock rising edge and is stable at the falling edge.
- R5: From the 17th bit period after the sync to the end of the frame, `pcmDout` is 0.
- R6: `pcmDin` is sampled at the bit-clock falling edge of bit periods 1 to 16 after the sync. The first sample goes to bit 0. After the 16th sample the word appears on `rxSample` with a one-cycle pulse on `rxValid`.
- R7: `rxSample` is a signed two's-complement value. A word with bit 15 set reads as negative, for example 16'h8000 reads as -32768.
- R8: A word presented with `txValid` is held until the frame boundary, which is the bit-clock rising edge that ends the sync. If no new word arrives, the held word is sent again. A word offered in the same cycle the boundary takes the held word is sent in the following frame.
- R9: With `slaveMode` high, `pcmTimingOe` is 0 and `pcmClkOut` and `pcmSyncOut` do not change. Bits shift out on the rising edges of `pcmClkIn` and are captured on its falling edges. A frame starts at the first rising edge after a falling edge at which `pcmSyncIn` was high.
- R10: During and right after reset, `pcmDout`, `rxValid`, `pcmClkOut` and `pcmSyncOut` are 0, and the held transmit word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| slaveMode | input | 1 | 1: follow external clock and sync; 0: generate them |
| txSample | input | 16 | Next sample to transmit |
| txValid | input | 1 | One-cycle strobe that loads `txSample` |
| rxSample | output | 16 | Last received sample, signed |
| rxValid | output | 1 | One-cycle strobe when `rxSample` is updated |
| pcmClkIn | input | 1 | External bit clock (slave mode) |
| pcmSyncIn | input | 1 | External frame sync (slave mode) |
| pcmDin | input | 1 | Serial data from the modem |
| pcmClkOut | output | 1 | Generated bit clock |
| pcmSyncOut | output | 1 | Generated frame sync |
| pcmTimingOe | output | 1 | Output enable for the clock and sync pads |
| pcmDout | output | 1 | Serial data to the modem |

## Verification
Two things can fall in one system cycle: the host offering a new transmit word on `txValid`, and the frame boundary taking the held word into the shifter. The bench watches the sync line fall and, at that moment, drives `txValid` into the same cycle in which the boundary takes its word. It then expects that frame's serial word to be the previous sample and the following frame's word to be the new one. The same run also checks ordinary offers made well inside a frame, and frames with no offer at all, which must repeat the held word.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  typedef struct packed {
    logic loadTx;
    logic shiftTx;
    logic idleTx;
    logic captureRx;
    logic finishRx;
  } pcmStrobe_t;
endpackage

// File: rtl/pcm_port_ctrl.sv
module pcm_port_ctrl
  import pcm_port_pkg::*;
#(
  parameter int FRAME_BITS  = 250,
  parameter int WORD_BITS   = 16,
  parameter int HI_CYC      = 6,
  parameter int LO_CYC_A    = 6,
  parameter int LO_CYC_B    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       slaveMode,
  input  logic       pcmClkIn,
  input  logic       pcmSyncIn,
  output logic       bclkOut,
  output logic       syncOut,
  output pcmStrobe_t strobe
);
  localparam int MAX_PH = (HI_CYC > LO_CYC_B) ? HI_CYC : LO_CYC_B;
  localparam int PH_W   = $clog2(MAX_PH + 1);
  localparam int POS_W  = $clog2(FRAME_BITS + 1);
  localparam logic [PH_W-1:0]  HI_LIM  = PH_W'(HI_CYC - 1);
  localparam logic [PH_W-1:0]  LOA_LIM = PH_W'(LO_CYC_A - 1);
  localparam logic [PH_W-1:0]  LOB_LIM = PH_W'(LO_CYC_B - 1);
  localparam logic [POS_W-1:0] LAST_BIT = POS_W'(FRAME_BITS - 1);
  localparam logic [POS_W-1:0] POS_IDLE = POS_W'(FRAME_BITS);
  localparam logic [POS_W-1:0] POS_WORD = POS_W'(WORD_BITS);

  // master divider: fixed high phase, low phase alternating between two lengths
  logic [PH_W-1:0]  phaseCnt, phaseLim;
  logic             bclkReg, loLong, mRise, mFall, syncReg;
  logic [POS_W-1:0] mCnt;

  always_comb phaseLim = bclkReg ? HI_LIM : (loLong ? LOB_LIM : LOA_LIM);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt <= '0;
      bclkReg  <= 1'b0;
      loLong   <= 1'b0;
      mRise    <= 1'b0;
      mFall    <= 1'b0;
      mCnt     <= LAST_BIT;
      syncReg  <= 1'b0;
    end else begin
      mRise <= 1'b0;
      mFall <= 1'b0;
      if (!slaveMode) begin
        if (phaseCnt == phaseLim) begin
          phaseCnt <= '0;
          bclkReg  <= ~bclkReg;
          if (bclkReg) begin
            mFall <= 1'b1;
          end else begin
            mRise   <= 1'b1;
            loLong  <= ~loLong;
            mCnt    <= (mCnt == LAST_BIT) ? '0 : mCnt + 1'b1;
            syncReg <= (mCnt == LAST_BIT);
          end
        end else begin
          phaseCnt <= phaseCnt + 1'b1;
        end
      end
    end
  end

  // slave path: synchroniser and edge detection
  logic [SYNC_STAGES-1:0] clkPipe, syncPipe;
  logic clkLast, sRise, sFall;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkPipe  <= '0;
      syncPipe <= '0;
      clkLast  <= 1'b0;
    end else begin
      clkPipe  <= {clkPipe[SYNC_STAGES-2:0], pcmClkIn};
      syncPipe <= {syncPipe[SYNC_STAGES-2:0], pcmSyncIn};
      clkLast  <= clkPipe[SYNC_STAGES-1];
    end
  end

  assign sRise = clkPipe[SYNC_STAGES-1] & ~clkLast;
  assign sFall = ~clkPipe[SYNC_STAGES-1] & clkLast;

  // common frame position tracking
  logic rise, fall, syncLvl, pending;
  logic [POS_W-1:0] pos;

  assign rise    = slaveMode ? sRise : mRise;
  assign fall    = slaveMode ? sFall : mFall;
  assign syncLvl = slaveMode ? syncPipe[SYNC_STAGES-1] : syncReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos     <= POS_IDLE;
      pending <= 1'b0;
    end else begin
      if (fall) pending <= syncLvl;
      if (rise) begin
        if (pending) begin
          pos     <= POS_W'(1);
          pending <= 1'b0;
        end else if (pos < POS_IDLE) begin
          pos <= pos + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.loadTx    = rise && pending;
    strobe.shiftTx   = rise && !pending && (pos >= POS_W'(1)) && (pos < POS_WORD);
    strobe.idleTx    = rise && !pending && !((pos >= POS_W'(1)) && (pos < POS_WORD));
    strobe.captureRx = fall && (pos >= POS_W'(1)) && (pos <= POS_WORD);
    strobe.finishRx  = fall && (pos == POS_WORD);
  end

  assign bclkOut = bclkReg;
  assign syncOut = syncReg;

  // checker state: cycles spent high in master mode
  logic [PH_W:0] hiRun;
  always_ff @(posedge clk) begin
    if (!rstN)                       hiRun <= '0;
    else if (!bclkReg)               hiRun <= '0;
    else if (!slaveMode)             hiRun <= hiRun + 1'b1;
  end

  assert_highLen_R1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bclkReg) |-> (hiRun == (PH_W+1)'(HI_CYC)));

  assert_syncRise_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncReg) |-> $rose(bclkReg));

  assert_syncFall_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(syncReg) |-> $rose(bclkReg));

  assert_slaveQuiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (slaveMode && $past(slaveMode)) |-> ($stable(bclkReg) && $stable(syncReg)));
endmodule

// File: rtl/pcm_port_datapath.sv
module pcm_port_datapath
  import pcm_port_pkg::*;
#(
  parameter int WORD_BITS = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  pcmStrobe_t                  strobe,
  input  logic [WORD_BITS-1:0]        txSample,
  input  logic                        txValid,
  input  logic                        pcmDin,
  output logic                        pcmDout,
  output logic signed [WORD_BITS-1:0] rxSample,
  output logic                        rxValid
);
  logic [WORD_BITS-1:0] txHold, txShift, rxShift;
  logic doutReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txHold  <= '0;
      txShift <= '0;
      doutReg <= 1'b0;
    end else begin
      if (txValid) txHold <= txSample;
      if (strobe.loadTx) begin
        doutReg <= txHold[0];
        txShift <= txHold >> 1;
      end else if (strobe.shiftTx) begin
        doutReg <= txShift[0];
        txShift <= txShift >> 1;
      end else if (strobe.idleTx) begin
        doutReg <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift  <= '0;
      rxSample <= '0;
      rxValid  <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (strobe.captureRx) rxShift <= {pcmDin, rxShift[WORD_BITS-1:1]};
      if (strobe.finishRx) begin
        rxSample <= $signed({pcmDin, rxShift[WORD_BITS-1:1]});
        rxValid  <= 1'b1;
      end
    end
  end

  assign pcmDout = doutReg;

  assert_rxPulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);
endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port
  import pcm_port_pkg::*;
#(
  parameter int FRAME_BITS  = 250,
  parameter int WORD_BITS   = 16,
  parameter int HI_CYC      = 6,
  parameter int LO_CYC_A    = 6,
  parameter int LO_CYC_B    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        slaveMode,
  input  logic [WORD_BITS-1:0]        txSample,
  input  logic                        txValid,
  output logic signed [WORD_BITS-1:0] rxSample,
  output logic                        rxValid,
  input  logic                        pcmClkIn,
  input  logic                        pcmSyncIn,
  input  logic                        pcmDin,
  output logic                        pcmClkOut,
  output logic                        pcmSyncOut,
  output logic                        pcmTimingOe,
  output logic                        pcmDout
);
  pcmStrobe_t strobe;

  pcm_port_ctrl #(
    .FRAME_BITS(FRAME_BITS), .WORD_BITS(WORD_BITS), .HI_CYC(HI_CYC),
    .LO_CYC_A(LO_CYC_A), .LO_CYC_B(LO_CYC_B), .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .slaveMode(slaveMode),
    .pcmClkIn(pcmClkIn), .pcmSyncIn(pcmSyncIn),
    .bclkOut(pcmClkOut), .syncOut(pcmSyncOut), .strobe(strobe)
  );

  pcm_port_datapath #(.WORD_BITS(WORD_BITS)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .txSample(txSample), .txValid(txValid), .pcmDin(pcmDin),
    .pcmDout(pcmDout), .rxSample(rxSample), .rxValid(rxValid)
  );

  assign pcmTimingOe = ~slaveMode;
endmodule

// File: tb/tb_pcm_voice_port.sv
module tb_pcm_voice_port;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slaveMode = 1'b0;
  logic [15:0] txSample = '0;
  logic txValid = 1'b0;
  logic signed [15:0] rxSample;
  logic rxValid;
  logic pcmClkIn = 1'b0, pcmSyncIn = 1'b0, benchDin = 1'b0;
  logic pcmDin, pcmClkOut, pcmSyncOut, pcmTimingOe, pcmDout;
  int checks = 0, failures = 0;
  logic [15:0] expTx = '0;

  always #4 clk = ~clk;

  assign pcmDin = slaveMode ? benchDin : pcmDout;

  pcm_voice_port dut (
    .clk(clk), .rstN(rstN), .slaveMode(slaveMode), .txSample(txSample),
    .txValid(txValid), .rxSample(rxSample), .rxValid(rxValid),
    .pcmClkIn(pcmClkIn), .pcmSyncIn(pcmSyncIn), .pcmDin(pcmDin),
    .pcmClkOut(pcmClkOut), .pcmSyncOut(pcmSyncOut),
    .pcmTimingOe(pcmTimingOe), .pcmDout(pcmDout)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int signedOf(input logic [15:0] w);
    return int'($signed(w));
  endfunction

  task automatic offer(input logic [15:0] w);
    txSample = w;
    txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
  endtask

  task automatic waitSyncRise();
    do @(negedge clk); while (pcmSyncOut);
    do @(negedge clk); while (!pcmSyncOut);
  endtask

  // one master frame with loopback; checks sync, tx bits, idle and rx
  task automatic masterFrame(input logic [15:0] newWord, input bit doOffer, input bit collide);
    int hi;
    logic [15:0] got;
    waitSyncRise();
    check(pcmClkOut == 1'b1, "R3 sync rises with clock", int'(pcmClkOut), 1);
    hi = 0;
    while (pcmSyncOut) begin hi++; @(negedge clk); end
    check(hi == 12 || hi == 13, "R3 sync width", hi, 12);
    if (doOffer && collide) offer(newWord);   // same cycle as frame word load
    for (int i = 0; i < 16; i++) begin
      do @(negedge clk); while (pcmClkOut);
      got[i] = pcmDout;
      do @(negedge clk); while (!pcmClkOut);
    end
    check(got == expTx, "R4 R8 serial word", int'(got), int'(expTx));
    for (int i = 0; i < 8; i++) begin
      do @(negedge clk); while (pcmClkOut);
      check(pcmDout == 1'b0, "R5 idle line", int'(pcmDout), 0);
      do @(negedge clk); while (!pcmClkOut);
    end
    check(rxSample == $signed(expTx), "R6 loopback rx", int'(rxSample), signedOf(expTx));
    check((rxSample < 0) == expTx[15], "R7 sign", int'(rxSample), signedOf(expTx));
    if (doOffer && !collide) offer(newWord);
    if (doOffer) expTx = newWord;
  endtask

  task automatic slaveBit(input logic syncV, input logic dinV, output logic doutS);
    pcmClkIn = 1'b1; pcmSyncIn = syncV; benchDin = dinV;
    repeat (9) @(negedge clk);
    doutS = pcmDout;
    @(negedge clk);
    pcmClkIn = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic slaveFrame(input logic [15:0] rxW);
    logic d, clkAtStart;
    logic [15:0] got;
    int pulses;
    clkAtStart = pcmClkOut;
    slaveBit(1'b1, 1'b0, d);
    pulses = 0;
    for (int i = 0; i < 16; i++) begin
      slaveBit(1'b0, rxW[i], d);
      got[i] = d;
    end
    for (int i = 0; i < 6; i++) begin
      slaveBit(1'b0, 1'b0, d);
      check(d == 1'b0, "R5 slave idle", int'(d), 0);
    end
    check(got == expTx, "R9 slave tx word", int'(got), int'(expTx));
    check(rxSample == $signed(rxW), "R9 slave rx word", int'(rxSample), signedOf(rxW));
    check(pcmTimingOe == 1'b0, "R9 no drive", int'(pcmTimingOe), 0);
    check(pcmClkOut == clkAtStart && pcmSyncOut == 1'b0, "R9 outputs frozen",
          int'(pcmClkOut), int'(clkAtStart));
  endtask

  // count rxValid pulses to judge single-cycle strobe
  int rxPulseLen = 0, rxPulseBad = 0;
  always @(negedge clk) begin
    if (rxValid) rxPulseLen++;
    else begin
      if (rxPulseLen > 1) rxPulseBad++;
      rxPulseLen = 0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int t0, t1, hiC, loC, prevLo;
    logic [15:0] w;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    // R10 reset state
    check(pcmDout == 0 && rxValid == 0, "R10 reset data", int'(pcmDout), 0);
    check(pcmClkOut == 0 && pcmSyncOut == 0, "R10 reset timing", int'(pcmClkOut), 0);
    rstN = 1'b1;
    // R1 phase lengths
    prevLo = 0;
    do @(negedge clk); while (!pcmClkOut);
    for (int p = 0; p < 8; p++) begin
      hiC = 0; loC = 0;
      while (pcmClkOut) begin hiC++; @(negedge clk); end
      while (!pcmClkOut) begin loC++; @(negedge clk); end
      check(hiC == 6, "R1 high phase", hiC, 6);
      check((loC == 6 || loC == 7) && loC != prevLo, "R1 low phase alternates", loC, prevLo);
      prevLo = loC;
    end
    // R2 frame length
    t0 = 0;
    waitSyncRise();
    do begin @(negedge clk); t0++; end while (pcmSyncOut);
    do begin @(negedge clk); t0++; end while (!pcmSyncOut);
    check(t0 == 3125, "R2 frame cycles", t0, 3125);
    t1 = t0;
    // master frames: first carries the reset word 0 (R10)
    masterFrame(16'h8000, 1'b1, 1'b0);
    masterFrame(16'h7FFF, 1'b1, 1'b0);
    masterFrame(16'h0000, 1'b0, 1'b0);        // R8 repeat
    masterFrame(16'h0001, 1'b1, 1'b1);        // R8 collision
    masterFrame(16'hFFFF, 1'b1, 1'b0);
    for (int k = 0; k < 4; k++) begin
      w = 16'($urandom);
      masterFrame(w, 1'b1, k[0]);
    end
    masterFrame(16'h0000, 1'b0, 1'b0);
    // slave mode
    @(negedge clk);
    slaveMode = 1'b1;
    repeat (20) @(negedge clk);
    slaveFrame(16'hA5C3);
    offer(16'h1234);
    expTx = 16'h1234;
    slaveFrame(16'h8000);
    for (int k = 0; k < 3; k++) begin
      w = 16'($urandom);
      offer(w);
      expTx = w;
      slaveFrame(16'($urandom));
    end
    check(rxPulseBad == 0, "R6 single-cycle valid", rxPulseBad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule